// File: doc/BRIEF.md
# Signaling Change-of-State Detector

This block watches the per-channel signaling codes of a framed line with 24 or 32 channels. At every multiframe boundary it copies each channel's code into a visible register. It also compares the code against the last value it accepted for that channel. A change is recorded in a per-channel status vector and, when the channel is enabled for alerts, in a latched summary bit. That bit can pull an active-low interrupt. A global integration option makes a new code count only after it has stayed the same for three multiframes in a row. This hides short signaling disturbances from the host.

The host reads the register bank and the status vector to find out which channels changed. It then clears the flags with write-one-to-clear strobes. The framer supplies the codes and the multiframe strobe.

Top module: `sig_cos_detector`

## Requirements
- R1: On each cycle with `mf_strobe` high, every channel's field of `sig_reg` loads that channel's field of `sig_in` (channel i uses bits i*SW to i*SW+SW-1). On all other cycles `sig_reg` holds its value.
- R2: The first `mf_strobe` after reset only sets each channel's reference value. No status bit and no summary bit is set by it.
- R3: With `integ_en` low, a sampled code that differs from the channel's reference is reported on that strobe and becomes the new reference.
- R4: With `integ_en` high, a code that differs from the reference is reported only on the third consecutive strobe that carries the same code, and then becomes the reference. A sample that breaks the run starts the count again from that sample. The setting applies to all channels at once.
- R5: With `integ_en` high, a code that returns to the reference value within three multiframes produces no report, and the reference stays unchanged.
- R6: `chg_status[i]` is set by any reported change on channel i, whatever `alert_en[i]` is. It stays set until a cycle with `clr_status[i]` high and no new change on that channel. A new change wins over a clear in the same cycle.
- R7: `cos_latched` is set by a reported change on any channel whose `alert_en` bit is high. It stays set until a cycle with `clr_summary` high and no such change. A new change wins over a clear in the same cycle.
- R8: `irq_n` is low exactly when both `cos_latched` and `irq_mask` are high. Otherwise it is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mf_strobe | input | 1 | One-cycle multiframe boundary pulse |
| sig_in | input | NCH*SW | Extracted signaling codes, channel i at bits i*SW +: SW |
| alert_en | input | NCH | Channels allowed to set the summary bit |
| integ_en | input | 1 | Global three-multiframe persistence filter enable |
| irq_mask | input | 1 | Lets the summary bit drive the interrupt |
| clr_status | input | NCH | Write-one-to-clear strobes for the status vector |
| clr_summary | input | 1 | Write-one-to-clear strobe for the summary bit |
| sig_reg | output | NCH*SW | Captured signaling register bank |
| chg_status | output | NCH | Per-channel change-status flags |
| cos_latched | output | 1 | Latched summary change-of-state bit |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest cases to reach are runs in the persistence filter that are broken or undone before they complete. Examples are a code held for two multiframes that then returns to the reference, or one that switches to a third code, all while clears and alert enables change around them. The stimulus draws each channel's next code from only three values and usually repeats the previous code, so partial runs of every length occur often. Directed sequences add a two-multiframe glitch, a restarted run, and a clear landing on the same cycle as a new change.

// File: rtl/sig_cos_pkg.sv
package sig_cos_pkg;
    typedef logic [1:0] agree_cnt_t;
    // count value at which the third agreeing sample is accepted
    localparam agree_cnt_t AGREE_LAST = 2'd2;
endpackage

// File: rtl/sig_cos_chan.sv
module sig_cos_chan
    import sig_cos_pkg::*;
#(
    parameter int SW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mf_strobe,
    input  logic          integ_en,
    input  logic          primed,
    input  logic [SW-1:0] sig_i,
    output logic [SW-1:0] sig_o,
    output logic          chg_o
);
    typedef struct packed {
        logic [SW-1:0] sig;
        logic [SW-1:0] ref_v;
        logic [SW-1:0] cand;
        agree_cnt_t    cnt;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     chg_d;

    always_comb begin
        st_d  = st_q;
        chg_d = 1'b0;
        if (mf_strobe) begin
            st_d.sig = sig_i;
            if (!primed) begin
                st_d.ref_v = sig_i;
                st_d.cand  = sig_i;
                st_d.cnt   = '0;
            end else if (sig_i == st_q.ref_v) begin
                st_d.cand = sig_i;
                st_d.cnt  = '0;
            end else if (!integ_en) begin
                st_d.ref_v = sig_i;
                st_d.cand  = sig_i;
                st_d.cnt   = '0;
                chg_d      = 1'b1;
            end else if (sig_i == st_q.cand && st_q.cnt != '0) begin
                if (st_q.cnt == AGREE_LAST) begin
                    st_d.ref_v = sig_i;
                    st_d.cnt   = '0;
                    chg_d      = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 2'd1;
                end
            end else begin
                st_d.cand = sig_i;
                st_d.cnt  = 2'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sig_o = st_q.sig;
    assign chg_o = chg_d;

    // R1: the bank only moves on a boundary
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !mf_strobe |=> $stable(sig_o));
    // R4: agreement counter never reaches its unused code
    a_r4_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt != 2'd3);
    // R4: a filtered report needs two earlier agreeing samples
    a_r4_integ_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_o && integ_en) |-> (st_q.cnt == AGREE_LAST));
    // R5: the reference only moves with a report
    a_r5_ref_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !chg_o) |=> $stable(st_q.ref_v));
endmodule

// File: rtl/sig_cos_status.sv
module sig_cos_status #(
    parameter int NCH = 24
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mf_strobe,
    input  logic [NCH-1:0] chg_i,
    input  logic [NCH-1:0] alert_en,
    input  logic [NCH-1:0] clr_status,
    input  logic           clr_summary,
    input  logic           irq_mask,
    output logic           primed_o,
    output logic [NCH-1:0] status_o,
    output logic           cos_o,
    output logic           irq_n_o
);
    typedef struct packed {
        logic           primed;
        logic [NCH-1:0] status;
        logic           cos;
    } stat_st_t;

    stat_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.primed = st_q.primed | mf_strobe;
        st_d.status = (st_q.status & ~clr_status) | chg_i;
        st_d.cos    = (st_q.cos & ~clr_summary) | (|(chg_i & alert_en));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign primed_o = st_q.primed;
    assign status_o = st_q.status;
    assign cos_o    = st_q.cos;
    assign irq_n_o  = ~(st_q.cos & irq_mask);

    // R6: every reported change shows up in the status vector
    a_r6_set: assert property (@(posedge clk) disable iff (!rst_n)
        (|chg_i) |=> ((status_o & $past(chg_i)) == $past(chg_i)));
    // R6: no flag disappears without its clear strobe
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(status_o) & ~$past(clr_status)) & ~status_o) == '0));
    // R7: summary rises only after an enabled channel changed
    a_r7_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cos_o) |-> $past(|(chg_i & alert_en)));
    // R7: summary holds without a clear
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cos_o && !clr_summary) |=> cos_o);
    // R2: nothing is flagged before the first boundary has primed the block
    a_r2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !primed_o |-> (chg_i == '0));
endmodule

// File: rtl/sig_cos_detector.sv
module sig_cos_detector #(
    parameter int NCH = 24,
    parameter int SW  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mf_strobe,
    input  logic [NCH*SW-1:0] sig_in,
    input  logic [NCH-1:0]    alert_en,
    input  logic              integ_en,
    input  logic              irq_mask,
    input  logic [NCH-1:0]    clr_status,
    input  logic              clr_summary,
    output logic [NCH*SW-1:0] sig_reg,
    output logic [NCH-1:0]    chg_status,
    output logic              cos_latched,
    output logic              irq_n
);
    logic [NCH-1:0] chg;
    logic           primed;

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        sig_cos_chan #(.SW(SW)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .mf_strobe(mf_strobe),
            .integ_en (integ_en),
            .primed   (primed),
            .sig_i    (sig_in[i*SW +: SW]),
            .sig_o    (sig_reg[i*SW +: SW]),
            .chg_o    (chg[i])
        );
    end

    sig_cos_status #(.NCH(NCH)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .mf_strobe  (mf_strobe),
        .chg_i      (chg),
        .alert_en   (alert_en),
        .clr_status (clr_status),
        .clr_summary(clr_summary),
        .irq_mask   (irq_mask),
        .primed_o   (primed),
        .status_o   (chg_status),
        .cos_o      (cos_latched),
        .irq_n_o    (irq_n)
    );
endmodule

// File: tb/sig_cos_detector_tb.sv
module sig_cos_detector_tb;
    localparam int NCH = 4;
    localparam int SW  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mf_strobe = 1'b0;
    logic [NCH*SW-1:0] sig_in = '0;
    logic [NCH-1:0]    alert_en = '0;
    logic              integ_en = 1'b0;
    logic              irq_mask = 1'b0;
    logic [NCH-1:0]    clr_status = '0;
    logic              clr_summary = 1'b0;
    logic [NCH*SW-1:0] sig_reg;
    logic [NCH-1:0]    chg_status;
    logic              cos_latched;
    logic              irq_n;

    sig_cos_detector #(.NCH(NCH), .SW(SW)) u_dut (.*);

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // bench-side model state
    logic [SW-1:0]  m_sig  [NCH];
    logic [SW-1:0]  m_ref  [NCH];
    logic [SW-1:0]  m_prev [NCH];
    int             m_run  [NCH];
    logic [NCH-1:0] m_stat;
    logic           m_sum;
    bit             m_primed;

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all(string stat_tag);
        logic [NCH*SW-1:0] es;
        for (int c = 0; c < NCH; c++) es[c*SW +: SW] = m_sig[c];
        check("R1 sig_reg", 64'(sig_reg), 64'(es));
        check(stat_tag, 64'(chg_status), 64'(m_stat));
        check("R7 cos_latched", 64'(cos_latched), 64'(m_sum));
        check("R8 irq_n", 64'(irq_n), 64'(!(m_sum && irq_mask)));
    endtask

    // one clock: called at a falling edge, returns at the next falling edge
    task automatic cyc(bit mf, logic [NCH*SW-1:0] v, logic [NCH-1:0] clr,
                       bit clrs, string stat_tag);
        logic [NCH-1:0] chg;
        mf_strobe = mf; sig_in = v; clr_status = clr; clr_summary = clrs;
        @(posedge clk);
        chg = '0;
        if (mf) begin
            for (int c = 0; c < NCH; c++) begin
                logic [SW-1:0] s;
                s = v[c*SW +: SW];
                m_sig[c] = s;
                if (!m_primed) begin
                    m_ref[c] = s; m_run[c] = 0;
                end else if (s == m_ref[c]) begin
                    m_run[c] = 0;
                end else begin
                    if (s == m_prev[c] && m_run[c] > 0) m_run[c]++;
                    else m_run[c] = 1;
                    if (m_run[c] >= (integ_en ? 3 : 1)) begin
                        m_ref[c] = s; m_run[c] = 0; chg[c] = 1'b1;
                    end
                end
                m_prev[c] = s;
            end
            m_primed = 1;
        end
        m_stat = (m_stat & ~clr) | chg;
        m_sum  = (m_sum & ~clrs) | (|(chg & alert_en));
        @(negedge clk);
        mf_strobe = 0; clr_status = '0; clr_summary = 0;
        check_all(stat_tag);
    endtask

    function automatic logic [NCH*SW-1:0] fill(logic [SW-1:0] a, logic [SW-1:0] b,
                                              logic [SW-1:0] c, logic [SW-1:0] d);
        return {d, c, b, a};
    endfunction

    initial begin
        #(8 * 50000);
        if (!finished) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [NCH*SW-1:0] cur;
        for (int c = 0; c < NCH; c++) begin
            m_sig[c] = '0; m_ref[c] = '0; m_prev[c] = '0; m_run[c] = 0;
        end
        m_stat = '0; m_sum = 0; m_primed = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_all("R6 reset status");

        // R2: first boundary only primes
        alert_en = '1; irq_mask = 1;
        cyc(1, fill(4'h5, 4'h9, 4'hA, 4'h3), '0, 0, "R2 first boundary");
        check("R2 no summary", 64'(cos_latched), 64'(0));

        // R3: unfiltered change reported at once
        cyc(1, fill(4'h6, 4'h9, 4'hA, 4'h3), '0, 0, "R3 immediate change");
        check("R3 ch0 flagged", 64'(chg_status), 64'(4'b0001));
        check("R8 irq low", 64'(irq_n), 64'(0));
        // R6/R7: clear flags together with a new change on channel 1
        cyc(1, fill(4'h6, 4'h1, 4'hA, 4'h3), 4'b0011, 1, "R6 set beats clear");
        check("R6 ch1 kept", 64'(chg_status), 64'(4'b0010));
        check("R7 set beats clear", 64'(cos_latched), 64'(1));
        cyc(0, fill(4'h6, 4'h1, 4'hA, 4'h3), 4'b1111, 1, "R6 clear");
        check("R6 cleared", 64'(chg_status), 64'(0));

        // R5: glitch of two boundaries returns; R4: restarted run
        integ_en = 1;
        cyc(1, fill(4'h7, 4'h2, 4'hA, 4'h3), '0, 0, "R5 glitch 1");
        cyc(1, fill(4'h7, 4'h2, 4'hA, 4'h3), '0, 0, "R5 glitch 2");
        cyc(1, fill(4'h6, 4'hC, 4'hA, 4'h3), '0, 0, "R5 glitch back");
        check("R5 no report", 64'(chg_status), 64'(0));
        cyc(1, fill(4'h6, 4'hC, 4'hA, 4'h3), '0, 0, "R4 run 2");
        cyc(1, fill(4'h6, 4'hC, 4'hA, 4'h3), '0, 0, "R4 run 3");
        check("R4 third sample reports", 64'(chg_status), 64'(4'b0010));
        alert_en = 4'b0000;
        cyc(0, cur, '1, 1, "R6 clear");
        cyc(1, fill(4'h6, 4'hC, 4'h4, 4'h3), '0, 0, "R4 all channels");
        cyc(1, fill(4'h6, 4'hC, 4'h4, 4'h3), '0, 0, "R4 all channels");
        cyc(1, fill(4'h6, 4'hC, 4'h4, 4'h3), '0, 0, "R4 all channels");
        check("R6 masked channel still flagged", 64'(chg_status), 64'(4'b0100));
        check("R7 masked channel no summary", 64'(cos_latched), 64'(0));

        // near-exhaustive sweep: few code values, frequent repeats
        cur = sig_in;
        for (int ph = 0; ph < 4; ph++) begin
            integ_en = ph[0];
            for (int k = 0; k < 150; k++) begin
                for (int c = 0; c < NCH; c++)
                    if ($urandom_range(0, 2) == 0)
                        cur[c*SW +: SW] = SW'($urandom_range(0, 2));
                alert_en = NCH'($urandom_range(0, 15));
                irq_mask = ($urandom_range(0, 3) != 0);
                cyc(1, cur, ($urandom_range(0, 3) == 0) ? NCH'($urandom_range(0, 15)) : '0,
                    ($urandom_range(0, 5) == 0), integ_en ? "R4 sweep status" : "R3 sweep status");
                cyc(0, cur, ($urandom_range(0, 3) == 0) ? NCH'($urandom_range(0, 15)) : '0,
                    ($urandom_range(0, 3) == 0), "R6 sweep idle");
            end
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule